// File: doc/BRIEF.md
# Auxiliary Register Address Generator

This block turns an operand reference into a 16-bit data-memory address in a single cycle. It owns a file of eight 16-bit pointer registers. For indirect references it reads the selected pointer, produces the address, and computes the pointer's next value. Register 0 also serves as the step register for every index-based update. For direct references it builds the address from a 9-bit page number or from the stack pointer, and it leaves the pointer file untouched.

Pointer updates include plain post-modify by one or by the step register, a pre-increment, and reverse-carry stepping for bit-reversed (FFT) traversal. There is also modulo stepping inside a circular buffer whose length is given on the `bk` input, plus offset and absolute forms that take a 16-bit long constant. A load port writes any pointer directly so that software-visible moves reach the file.

Top module: `aux_addr_gen`

## Requirements
- R1: After reset every pointer register reads 0.
- R2: With `dir_en`=1 and `cpl`=0, `addr` is {`dp`, `dofs`}: page in bits 15:7, offset in bits 6:0. No pointer changes, even when `acc_en`=1.
- R3: With `dir_en`=1 and `cpl`=1, `addr` is `sp` plus the zero-extended `dofs`, modulo 2^16.
- R4: Post-modify mode codes: 1 is minus one, 2 is plus one, 4 is minus AR0, 5 is plus AR0 (AR0 is pointer 0). `addr` is the old value, and the pointer wraps modulo 2^16.
- R5: Mode 3 adds one first. Both `addr` and the new pointer value are the incremented value.
- R6: Mode 7 adds AR0 and mode 6 subtracts AR0, with the carry or borrow travelling from bit 15 toward bit 0. `addr` is the old value.
- R7: Circular modes use `addr` = old value. Mode 8 is minus one, 10 is plus one, 9 is minus AR0, 11 is plus AR0. Let N be the smallest integer with 2^N > `bk`. The index is the low N bits. A result at or above `bk` loses `bk`, a negative result gains `bk`, and the bits above N are kept.
- R8: With `bk`=0, the circular modes step by plain modulo-2^16 arithmetic.
- R9: Offset modes give `addr` = pointer + `lk`. Mode 12 keeps the pointer. Mode 13 writes the sum back. Mode 14 applies the circular rule of R7 with step `lk`, and uses that result both as `addr` and as the new pointer.
- R10: Mode 15 gives `addr` = `lk`. Mode 15 and mode 0 (`addr` = pointer) leave the pointer unchanged.
- R11: With `ld_en`=1, `ld_val` is written to pointer `ld_sel` at the next edge. If that same pointer is also being updated by an access, the load wins. An update of a different pointer still happens.
- R12: `addr` and `ar_new` are combinational in the cycle of the request, and the pointer takes `ar_new` at the next rising edge. With `acc_en`=0 and `ld_en`=0 no pointer changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_en | input | 1 | Indirect access request |
| dir_en | input | 1 | Direct address request (overrides acc_en) |
| ar_sel | input | 3 | Selected pointer register |
| mode | input | 4 | Indirect mode code |
| lk | input | 16 | Long offset / absolute address |
| bk | input | 16 | Circular buffer length |
| cpl | input | 1 | Direct form: 0 page, 1 stack |
| dp | input | 9 | Page number |
| sp | input | 16 | Stack pointer |
| dofs | input | 7 | Instruction offset field |
| ld_en | input | 1 | Pointer load strobe |
| ld_sel | input | 3 | Pointer to load |
| ld_val | input | 16 | Value to load |
| addr | output | 16 | Data-memory address |
| ar_new | output | 16 | Value the selected pointer holds after the edge |

## Verification
The address and `ar_new` are due in the same cycle as the request. The bench therefore samples them a short delay after driving the inputs on the falling edge, before any rising edge. The written-back pointer is due one rising edge later. The bench checks it by issuing a mode-0 read of the same pointer on the following falling edge and comparing `addr`. Loads settle at one edge, so every vector preloads AR0 and the target pointer before its request.

// File: rtl/agu_pkg.sv
package agu_pkg;
    typedef enum logic [3:0] {
        M_NONE      = 4'd0,
        M_POST_DEC  = 4'd1,
        M_POST_INC  = 4'd2,
        M_PRE_INC   = 4'd3,
        M_POST_SUB0 = 4'd4,
        M_POST_ADD0 = 4'd5,
        M_REV_SUB0  = 4'd6,
        M_REV_ADD0  = 4'd7,
        M_CIRC_DEC  = 4'd8,
        M_CIRC_SUB0 = 4'd9,
        M_CIRC_INC  = 4'd10,
        M_CIRC_ADD0 = 4'd11,
        M_OFS_KEEP  = 4'd12,
        M_OFS_WB    = 4'd13,
        M_OFS_CIRC  = 4'd14,
        M_ABS       = 4'd15
    } agu_mode_e;
endpackage

// File: rtl/agu_revcarry.sv
module agu_revcarry #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] y
);
    logic [W-1:0] ra, rb, rs;

    // mirror the operands so an ordinary adder carries from the MSB downward
    for (genvar i = 0; i < W; i++) begin : g_mirror
        assign ra[i] = a[W-1-i];
        assign rb[i] = b[W-1-i];
        assign y[i]  = rs[W-1-i];
    end

    assign rs = sub ? (ra - rb) : (ra + rb);
endmodule

// File: rtl/agu_circ.sv
module agu_circ #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] cur,
    input  logic [W-1:0] bk,
    input  logic [W-1:0] mag,
    input  logic         neg,
    output logic [W-1:0] res
);
    localparam int SW = W + 2;

    logic [W-1:0]         mask;
    logic signed [SW-1:0] idx_s, step_s, sum_s, bk_s;

    always_comb begin
        for (int i = 0; i < W; i++) begin
            mask[i] = |(bk >> i);
        end
        idx_s  = {2'b00, cur & mask};
        bk_s   = {2'b00, bk};
        step_s = neg ? -$signed({2'b00, mag}) : $signed({2'b00, mag});
        sum_s  = idx_s + step_s;
        if (bk == '0) begin
            res = neg ? (cur - mag) : (cur + mag);
        end else begin
            if (sum_s < 0) begin
                sum_s = sum_s + bk_s;
            end else if (sum_s >= bk_s) begin
                sum_s = sum_s - bk_s;
            end
            res = (cur & ~mask) | (sum_s[W-1:0] & mask);
        end
    end

    AST_CIRC_INDEX_IN_BUFFER: assert property (@(posedge clk) disable iff (!rst_n)
        ((bk != '0) && ((cur & mask) < bk) && (mag <= bk)) |-> ((res & mask) < bk)); // R7
endmodule

// File: rtl/aux_addr_gen.sv
module aux_addr_gen #(
    parameter int W    = 16,
    parameter int NREG = 8,
    parameter int PGW  = 9,
    parameter int DOFW = 7
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    acc_en,
    input  logic                    dir_en,
    input  logic [$clog2(NREG)-1:0] ar_sel,
    input  logic [3:0]              mode,
    input  logic [W-1:0]            lk,
    input  logic [W-1:0]            bk,
    input  logic                    cpl,
    input  logic [PGW-1:0]          dp,
    input  logic [W-1:0]            sp,
    input  logic [DOFW-1:0]         dofs,
    input  logic                    ld_en,
    input  logic [$clog2(NREG)-1:0] ld_sel,
    input  logic [W-1:0]            ld_val,
    output logic [W-1:0]            addr,
    output logic [W-1:0]            ar_new
);
    import agu_pkg::*;

    localparam int PADW = W - DOFW;

    typedef struct packed {
        logic [NREG-1:0][W-1:0] ar;
    } regs_t;

    regs_t        st_q, st_d;
    agu_mode_e    m;
    logic [W-1:0] cur, ar0, rev_y, circ_y, circ_mag, nxt, ind_addr, dir_addr;
    logic         circ_neg, wr, upd;

    assign m   = agu_mode_e'(mode);
    assign cur = st_q.ar[ar_sel];
    assign ar0 = st_q.ar[0];

    agu_revcarry #(.W(W)) i_rev (
        .a   (cur),
        .b   (ar0),
        .sub (m == M_REV_SUB0),
        .y   (rev_y)
    );

    always_comb begin
        circ_neg = (m == M_CIRC_DEC) || (m == M_CIRC_SUB0);
        if ((m == M_CIRC_DEC) || (m == M_CIRC_INC)) begin
            circ_mag = W'(1);
        end else if (m == M_OFS_CIRC) begin
            circ_mag = lk;
        end else begin
            circ_mag = ar0;
        end
    end

    agu_circ #(.W(W)) i_circ (
        .clk   (clk),
        .rst_n (rst_n),
        .cur   (cur),
        .bk    (bk),
        .mag   (circ_mag),
        .neg   (circ_neg),
        .res   (circ_y)
    );

    always_comb begin
        ind_addr = cur;
        nxt      = cur;
        wr       = 1'b1;
        case (m)
            M_NONE:      wr = 1'b0;
            M_POST_DEC:  nxt = cur - W'(1);
            M_POST_INC:  nxt = cur + W'(1);
            M_PRE_INC: begin
                nxt      = cur + W'(1);
                ind_addr = nxt;
            end
            M_POST_SUB0: nxt = cur - ar0;
            M_POST_ADD0: nxt = cur + ar0;
            M_REV_SUB0,
            M_REV_ADD0:  nxt = rev_y;
            M_CIRC_DEC,
            M_CIRC_SUB0,
            M_CIRC_INC,
            M_CIRC_ADD0: nxt = circ_y;
            M_OFS_KEEP: begin
                ind_addr = cur + lk;
                wr       = 1'b0;
            end
            M_OFS_WB: begin
                nxt      = cur + lk;
                ind_addr = nxt;
            end
            M_OFS_CIRC: begin
                nxt      = circ_y;
                ind_addr = circ_y;
            end
            M_ABS: begin
                ind_addr = lk;
                wr       = 1'b0;
            end
            default:     wr = 1'b0;
        endcase

        dir_addr = cpl ? (sp + {{PADW{1'b0}}, dofs}) : {dp, dofs};
        upd      = acc_en && !dir_en && wr;
        addr     = dir_en ? dir_addr : ind_addr;
        ar_new   = upd ? nxt : cur;

        st_d = st_q;
        if (upd) begin
            st_d.ar[ar_sel] = nxt;
        end
        if (ld_en) begin
            st_d.ar[ld_sel] = ld_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        ld_en |=> (st_q.ar[$past(ld_sel)] == $past(ld_val))); // R11
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_en && !acc_en) |=> $stable(st_q)); // R12
    AST_DIRECT_NO_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_en && !ld_en) |=> $stable(st_q)); // R2
    AST_WB_MATCHES: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && !dir_en && !ld_en) |=> (st_q.ar[$past(ar_sel)] == $past(ar_new))); // R12
endmodule

// File: tb/test_aux_addr_gen.sv
module test_aux_addr_gen;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [3:0]  mode;
        logic [15:0] init;
        logic [15:0] ar0;
        logic [15:0] bk;
        logic [15:0] lk;
        logic [15:0] exp_addr;
        logic [15:0] exp_next;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t VEC [NV] = '{
        '{4'd1,  16'h0100, 16'h0000, 16'h0000, 16'h0000, 16'h0100, 16'h00FF},
        '{4'd2,  16'hFFFF, 16'h0000, 16'h0000, 16'h0000, 16'hFFFF, 16'h0000},
        '{4'd3,  16'h1234, 16'h0000, 16'h0000, 16'h0000, 16'h1235, 16'h1235},
        '{4'd4,  16'h0050, 16'h0010, 16'h0000, 16'h0000, 16'h0050, 16'h0040},
        '{4'd5,  16'h0050, 16'h0030, 16'h0000, 16'h0000, 16'h0050, 16'h0080},
        '{4'd7,  16'h0000, 16'h0008, 16'h0000, 16'h0000, 16'h0000, 16'h0008},
        '{4'd7,  16'h0008, 16'h0008, 16'h0000, 16'h0000, 16'h0008, 16'h0004},
        '{4'd7,  16'h000C, 16'h0008, 16'h0000, 16'h0000, 16'h000C, 16'h0002},
        '{4'd6,  16'h0004, 16'h0008, 16'h0000, 16'h0000, 16'h0004, 16'h0008},
        '{4'd6,  16'h0000, 16'h0008, 16'h0000, 16'h0000, 16'h0000, 16'h000F},
        '{4'd10, 16'h0104, 16'h0000, 16'h0005, 16'h0000, 16'h0104, 16'h0100},
        '{4'd8,  16'h0100, 16'h0000, 16'h0005, 16'h0000, 16'h0100, 16'h0104},
        '{4'd11, 16'h0208, 16'h0003, 16'h000A, 16'h0000, 16'h0208, 16'h0201},
        '{4'd9,  16'h0201, 16'h0003, 16'h000A, 16'h0000, 16'h0201, 16'h0208},
        '{4'd10, 16'h0307, 16'h0000, 16'h0008, 16'h0000, 16'h0307, 16'h0300},
        '{4'd10, 16'h0104, 16'h0000, 16'h0000, 16'h0000, 16'h0104, 16'h0105},
        '{4'd12, 16'h1000, 16'h0000, 16'h0000, 16'h0234, 16'h1234, 16'h1000},
        '{4'd13, 16'h1000, 16'h0000, 16'h0000, 16'h0234, 16'h1234, 16'h1234},
        '{4'd14, 16'h0403, 16'h0000, 16'h0006, 16'h0004, 16'h0401, 16'h0401},
        '{4'd15, 16'h5555, 16'h0000, 16'h0000, 16'hBEEF, 16'hBEEF, 16'h5555},
        '{4'd0,  16'hA5A5, 16'h0000, 16'h0000, 16'h0000, 16'hA5A5, 16'hA5A5},
        '{4'd8,  16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'hFFFF}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_en = 1'b0, dir_en = 1'b0, cpl = 1'b0, ld_en = 1'b0;
    logic [2:0]  ar_sel = '0, ld_sel = '0;
    logic [3:0]  mode = '0;
    logic [15:0] lk = '0, bk = '0, sp = '0, ld_val = '0;
    logic [8:0]  dp = '0;
    logic [6:0]  dofs = '0;
    logic [15:0] addr, ar_new;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    aux_addr_gen i_aux_addr_gen (
        .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .dir_en(dir_en),
        .ar_sel(ar_sel), .mode(mode), .lk(lk), .bk(bk), .cpl(cpl),
        .dp(dp), .sp(sp), .dofs(dofs), .ld_en(ld_en), .ld_sel(ld_sel),
        .ld_val(ld_val), .addr(addr), .ar_new(ar_new)
    );

    task automatic chk(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic string req_of(input logic [3:0] md, input logic [15:0] b);
        case (md)
            4'd1, 4'd2, 4'd4, 4'd5:  return "R4";
            4'd3:                    return "R5";
            4'd6, 4'd7:              return "R6";
            4'd8, 4'd9, 4'd10, 4'd11: return (b == 16'h0) ? "R8" : "R7";
            4'd12, 4'd13, 4'd14:     return "R9";
            default:                 return "R10";
        endcase
    endfunction

    task automatic load(input logic [2:0] s, input logic [15:0] v);
        @(negedge clk);
        ld_en = 1'b1; ld_sel = s; ld_val = v;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    // read pointer s through a mode-0 request; address is combinational
    task automatic peek(input logic [2:0] s, output logic [15:0] v);
        acc_en = 1'b0; dir_en = 1'b0; mode = 4'd0; ar_sel = s;
        #1;
        v = addr;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        for (int s = 0; s < 8; s++) begin
            peek(3'(s), v);
            chk("R1", "reset value", v, 16'h0000);
        end

        // R4..R10 table walk, pointer 3 with AR0 preloaded
        for (int k = 0; k < NV; k++) begin
            load(3'd0, VEC[k].ar0);
            load(3'd3, VEC[k].init);
            acc_en = 1'b1; dir_en = 1'b0; ar_sel = 3'd3;
            mode = VEC[k].mode; lk = VEC[k].lk; bk = VEC[k].bk;
            #1;
            chk(req_of(VEC[k].mode, VEC[k].bk), "addr", addr, VEC[k].exp_addr);
            chk("R12", "ar_new same cycle", ar_new, VEC[k].exp_next);
            @(negedge clk);
            peek(3'd3, v);
            chk(req_of(VEC[k].mode, VEC[k].bk), "pointer after edge", v, VEC[k].exp_next);
        end
        bk = '0; lk = '0;

        // R2: page form, and no pointer change despite acc_en with post-increment
        load(3'd5, 16'h0042);
        @(negedge clk);
        dir_en = 1'b1; acc_en = 1'b1; ar_sel = 3'd5; mode = 4'd2;
        cpl = 1'b0; dp = 9'h1AB; dofs = 7'h45;
        #1;
        chk("R2", "page address", addr, 16'hD5C5);
        @(negedge clk);
        peek(3'd5, v);
        chk("R2", "pointer untouched by direct", v, 16'h0042);

        // R3: stack form with carry out of low bits
        @(negedge clk);
        dir_en = 1'b1; cpl = 1'b1; sp = 16'h2FF0; dofs = 7'h7F;
        #1;
        chk("R3", "stack address", addr, 16'h306F);
        sp = 16'hFFF0; dofs = 7'h20;
        #1;
        chk("R3", "stack address wrap", addr, 16'h0010);
        dir_en = 1'b0; acc_en = 1'b0;

        // R12: idle cycles keep pointers
        repeat (2) @(negedge clk);
        peek(3'd5, v);
        chk("R12", "idle hold", v, 16'h0042);

        // R11: load beats update on same pointer
        load(3'd3, 16'h0010);
        @(negedge clk);
        acc_en = 1'b1; ar_sel = 3'd3; mode = 4'd2;
        ld_en = 1'b1; ld_sel = 3'd3; ld_val = 16'h7777;
        @(negedge clk);
        ld_en = 1'b0; acc_en = 1'b0;
        peek(3'd3, v);
        chk("R11", "load wins same pointer", v, 16'h7777);

        // R11: load on other pointer, update still applies
        @(negedge clk);
        acc_en = 1'b1; ar_sel = 3'd3; mode = 4'd2;
        ld_en = 1'b1; ld_sel = 3'd4; ld_val = 16'h4444;
        @(negedge clk);
        ld_en = 1'b0; acc_en = 1'b0;
        peek(3'd3, v);
        chk("R11", "update alongside load", v, 16'h7778);
        peek(3'd4, v);
        chk("R11", "load other pointer", v, 16'h4444);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule